// File: doc/BRIEF.md
# Timer Host Register Interface

This block is the host-side register front end for a three-channel interval timer. A host issues single-byte reads and writes on a 2-bit address. The block steers each access to one of three channel data ports or to the control port. It decodes control words, collects count bytes into 16-bit load values, and returns live or frozen count values one byte at a time. The counting engines sit behind a per-channel interface: a count-load strobe with its value, a configuration-update strobe with the operating mode and BCD flag, and a latch-request strobe. Each engine supplies its live 16-bit count back to this block.

Each channel owns a write byte pointer FSM, a read byte pointer FSM and a snapshot register.

- **Write pointer FSM** has two states, `WP_LOW` (the next byte is the low byte) and `WP_HIGH` (the next byte is the high byte).
  - In word access, a data write in `WP_LOW` stores the byte and moves to `WP_HIGH`.
  - A data write in `WP_HIGH` issues the load and returns to `WP_LOW`.
  - In low-only and high-only access the FSM stays in `WP_LOW` and every write loads.
- **Read pointer FSM** has two states, `RP_FIRST` and `RP_SECOND`.
  - In word access, each data read toggles between them.
  - In single-byte access it stays in `RP_FIRST`.
- **Snapshot register** is either empty or holding.
  - A latch command moves an empty snapshot to holding.
  - The read that completes the access mode's byte sequence moves it back to empty.
- **Control word effect**: a control word that configures the channel forces `WP_LOW`, `RP_FIRST` and an empty snapshot.

Top module: `timer_host_if`

## Requirements
- R1: Address 0, 1 and 2 reach the data port of channel 0, 1 and 2 respectively, and address 3 is the control port. A data write never produces a count load on any other channel.
- R2: A control-port byte carries the channel in bits 7:6, the access mode in bits 5:4, the operating mode in bits 3:1 and BCD in bit 0. When the access mode is not 00, `cfg_update` pulses for the selected channel on the cycle after the write, with `cfg_mode` and `cfg_bcd` holding the decoded fields.
- R3: Operating modes 6 and 7 (binary 110, 111) are forwarded as 2 and 3 respectively. All other modes are forwarded unchanged.
- R4: In access mode 01 each data write loads {8'h00, byte}. In access mode 10 each data write loads {byte, 8'h00}. The `cnt_load` bit pulses on the cycle after the write.
- R5: In access mode 11 the first data write is the low byte and the second is the high byte. No load occurs after the first write. The load of {high, low} pulses on the cycle after the second write.
- R6: Data reads return the low byte in access mode 01 and the high byte in access mode 10. In access mode 11 they alternate low then high. `bus_rdata` is valid in the same cycle as `bus_rd`.
- R7: Access mode 00 is a latch command. It captures the channel's live count at the write and pulses `latch_req` on the next cycle. It leaves the channel's access mode and both pointers unchanged. Reads return the snapshot until the access mode's bytes have all been read, and then return the live count again.
- R8: A latch command to a channel whose snapshot has not been fully read is ignored: the snapshot keeps its value and `latch_req` does not pulse.
- R9: A configuring control word resets the channel's write pointer to the low byte and its read pointer to the first byte, and it discards any snapshot.
- R10: A control word with channel select 11 is ignored. It produces no update and no latch, and it changes no channel's mode or pointers.
- R11: After reset the access mode is 11 with both pointers at their first byte, no snapshot is held, and all strobes are low.
- R12: Each channel's pointers and partial low byte are independent of accesses to the other channels.
- R13: A read of address 3 returns 8'h00 and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Port select: 0..2 channel data, 3 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (advances read pointers) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and pointer state |
| live_count | input | 48 | Live counts from the channel engines, channel n in bits 16n+15:16n |
| cnt_load | output | 3 | One-cycle count-load strobe per channel |
| cnt_value | output | 48 | Assembled count per channel, valid with `cnt_load` |
| cfg_update | output | 3 | One-cycle configuration strobe per channel |
| cfg_mode | output | 3 | Normalized operating mode of the last configuration |
| cfg_bcd | output | 1 | BCD flag of the last configuration |
| latch_req | output | 3 | One-cycle latch-request strobe per channel |

## Verification
The embedded properties watch the following on every cycle:
- at most one channel loads at a time;
- a load only ever follows a data write;
- a word-mode low byte never loads;
- a configuring control word always leaves both pointers at their first byte with no snapshot;
- a held snapshot stays frozen until a read or reconfiguration;
- aliased mode codes never reach the channel interface;
- channel-select 11 produces no strobe.

The exact assembled count values, the byte order seen on reads, the return to live data once a snapshot is consumed, and the survival of a half-written count across a latch or an ignored control word are not visible to a single-cycle property. Only the directed scenarios show these, because they depend on byte sequences spread over many accesses.

// File: rtl/timer_host_pkg.sv
package timer_host_pkg;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_WORD  = 2'b11
    } acc_e;

    typedef enum logic {
        WP_LOW  = 1'b0,
        WP_HIGH = 1'b1
    } wptr_e;

    typedef enum logic {
        RP_FIRST  = 1'b0,
        RP_SECOND = 1'b1
    } rptr_e;

    typedef struct packed {
        logic [1:0] sel;
        acc_e       acc;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_word_t;

    function automatic logic [2:0] norm_mode(input logic [2:0] m);
        if (m[1]) return {1'b0, m[1:0]};
        return m;
    endfunction

endpackage

// File: rtl/timer_host_decode.sv
module timer_host_decode
    import timer_host_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 2
) (
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [7:0]     bus_wdata,
    output logic [NCH-1:0] data_wr,
    output logic [NCH-1:0] data_rd,
    output logic [NCH-1:0] cfg_hit,
    output logic [NCH-1:0] latch_hit,
    output acc_e           new_acc,
    output logic [2:0]     new_mode,
    output logic           new_bcd
);
    localparam logic [AW-1:0] CW_ADDR = AW'(NCH);

    ctrl_word_t cw;
    logic       cw_wr;

    always_comb begin
        cw       = ctrl_word_t'(bus_wdata);
        cw_wr    = bus_wr && (bus_addr == CW_ADDR);
        new_acc  = cw.acc;
        new_mode = norm_mode(cw.mode);
        new_bcd  = cw.bcd;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        always_comb begin
            data_wr[g]   = bus_wr && (bus_addr == AW'(g));
            data_rd[g]   = bus_rd && (bus_addr == AW'(g));
            cfg_hit[g]   = cw_wr && (cw.sel == 2'(g)) && (cw.acc != ACC_LATCH);
            latch_hit[g] = cw_wr && (cw.sel == 2'(g)) && (cw.acc == ACC_LATCH);
        end
    end

endmodule

// File: rtl/timer_host_chan.sv
module timer_host_chan
    import timer_host_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic          cfg_hit,
    input  logic          latch_hit,
    input  acc_e          new_acc,
    input  logic [7:0]    wdata,
    input  logic [CW-1:0] live,
    output logic [7:0]    rdata,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          latch_pulse
);
    localparam int HB = CW - 8;

    acc_e          acc_q, acc_d;
    wptr_e         wptr_q, wptr_d;
    rptr_e         rptr_q, rptr_d;
    logic [7:0]    low_q, low_d;
    logic          lat_v_q, lat_v_d;
    logic [CW-1:0] lat_q, lat_d;
    logic          load_d, latp_d;
    logic [CW-1:0] load_val_d;
    logic [CW-1:0] src;

    // next-state logic for both pointer FSMs and the snapshot
    always_comb begin
        acc_d      = acc_q;
        wptr_d     = wptr_q;
        rptr_d     = rptr_q;
        low_d      = low_q;
        lat_v_d    = lat_v_q;
        lat_d      = lat_q;
        load_d     = 1'b0;
        load_val_d = load_val;
        latp_d     = 1'b0;
        if (cfg_hit) begin
            acc_d   = new_acc;
            wptr_d  = WP_LOW;
            rptr_d  = RP_FIRST;
            lat_v_d = 1'b0;
        end else begin
            if (data_wr) begin
                unique case (acc_q)
                    ACC_LO: begin
                        load_d     = 1'b1;
                        load_val_d = {{HB{1'b0}}, wdata};
                    end
                    ACC_HI: begin
                        load_d     = 1'b1;
                        load_val_d = {wdata, {HB{1'b0}}} << (HB - 8);
                    end
                    ACC_WORD: begin
                        unique case (wptr_q)
                            WP_LOW: begin
                                low_d  = wdata;
                                wptr_d = WP_HIGH;
                            end
                            WP_HIGH: begin
                                load_d     = 1'b1;
                                load_val_d = CW'({wdata, low_q});
                                wptr_d     = WP_LOW;
                            end
                        endcase
                    end
                    default: ;
                endcase
            end
            if (data_rd) begin
                unique case (acc_q)
                    ACC_LO, ACC_HI: lat_v_d = 1'b0;
                    ACC_WORD: begin
                        unique case (rptr_q)
                            RP_FIRST:  rptr_d = RP_SECOND;
                            RP_SECOND: begin
                                rptr_d  = RP_FIRST;
                                lat_v_d = 1'b0;
                            end
                        endcase
                    end
                    default: ;
                endcase
            end
            if (latch_hit && !lat_v_q) begin
                lat_v_d = 1'b1;
                lat_d   = live;
                latp_d  = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= ACC_WORD;
            wptr_q  <= WP_LOW;
            rptr_q  <= RP_FIRST;
            low_q   <= '0;
            lat_v_q <= 1'b0;
            lat_q   <= '0;
        end else begin
            acc_q   <= acc_d;
            wptr_q  <= wptr_d;
            rptr_q  <= rptr_d;
            low_q   <= low_d;
            lat_v_q <= lat_v_d;
            lat_q   <= lat_d;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load        <= 1'b0;
            load_val    <= '0;
            latch_pulse <= 1'b0;
        end else begin
            load        <= load_d;
            load_val    <= load_val_d;
            latch_pulse <= latp_d;
        end
    end

    // read byte selection
    always_comb begin
        src = lat_v_q ? lat_q : live;
        unique case (acc_q)
            ACC_HI:   rdata = src[15:8];
            ACC_WORD: rdata = (rptr_q == RP_FIRST) ? src[7:0] : src[15:8];
            default:  rdata = src[7:0];
        endcase
    end

    AST_LOAD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(data_wr)); // R4

    AST_WORD_LOW_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !cfg_hit && acc_q == ACC_WORD && wptr_q == WP_LOW) |=> !load); // R5

    AST_CFG_RESETS_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |=> (wptr_q == WP_LOW && rptr_q == RP_FIRST && !lat_v_q)); // R9

    AST_SNAPSHOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_v_q && !cfg_hit && !data_rd) |=> (lat_v_q && $stable(lat_q))); // R8

endmodule

// File: rtl/timer_host_if.sv
module timer_host_if
    import timer_host_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 16,
    parameter int AW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NCH*CW-1:0] live_count,
    output logic [NCH-1:0]    cnt_load,
    output logic [NCH*CW-1:0] cnt_value,
    output logic [NCH-1:0]    cfg_update,
    output logic [2:0]        cfg_mode,
    output logic              cfg_bcd,
    output logic [NCH-1:0]    latch_req
);
    logic [NCH-1:0] data_wr, data_rd, cfg_hit, latch_hit;
    acc_e           new_acc;
    logic [2:0]     new_mode;
    logic           new_bcd;
    logic [7:0]     ch_rdata [NCH];

    timer_host_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .cfg_hit   (cfg_hit),
        .latch_hit (latch_hit),
        .new_acc   (new_acc),
        .new_mode  (new_mode),
        .new_bcd   (new_bcd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        timer_host_chan #(.CW(CW)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .data_wr     (data_wr[g]),
            .data_rd     (data_rd[g]),
            .cfg_hit     (cfg_hit[g]),
            .latch_hit   (latch_hit[g]),
            .new_acc     (new_acc),
            .wdata       (bus_wdata),
            .live        (live_count[g*CW +: CW]),
            .rdata       (ch_rdata[g]),
            .load        (cnt_load[g]),
            .load_val    (cnt_value[g*CW +: CW]),
            .latch_pulse (latch_req[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_update <= '0;
            cfg_mode   <= '0;
            cfg_bcd    <= 1'b0;
        end else begin
            cfg_update <= cfg_hit;
            if (|cfg_hit) begin
                cfg_mode <= new_mode;
                cfg_bcd  <= new_bcd;
            end
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(i)) bus_rdata = ch_rdata[i];
        end
    end

    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cnt_load)); // R1

    AST_SEL3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(NCH) && bus_wdata[7:6] == 2'b11)
        |=> (cfg_update == '0 && latch_req == '0)); // R10

    AST_NO_ALIAS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_update != '0) |-> (cfg_mode[2:1] != 2'b11)); // R3

endmodule

// File: tb/timer_host_if_tb_top.sv
`timescale 1ns/1ps
module timer_host_if_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] live_count = '0;
    logic [2:0]  cnt_load;
    logic [47:0] cnt_value;
    logic [2:0]  cfg_update;
    logic [2:0]  cfg_mode;
    logic        cfg_bcd;
    logic [2:0]  latch_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    timer_host_if dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .live_count(live_count), .cnt_load(cnt_load), .cnt_value(cnt_value),
        .cfg_update(cfg_update), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
        .latch_req(latch_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_live(input int ch, input logic [15:0] v);
        live_count[ch*16 +: 16] = v;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R11 load", 32'(cnt_load), 0);
        chk("R11 cfg", 32'(cfg_update), 0);
        chk("R11 latch", 32'(latch_req), 0);
        set_live(0, 16'h1234);
        rd(0, d); chk("R11 rd lo", 32'(d), 32'h34);
        rd(0, d); chk("R11 rd hi", 32'(d), 32'h12);
    endtask

    task automatic t_word_write();
        wr(3, 8'b00_11_010_1);
        chk("R2 upd", 32'(cfg_update), 32'b001);
        chk("R2 mode", 32'(cfg_mode), 2);
        chk("R2 bcd", 32'(cfg_bcd), 1);
        wr(0, 8'hCD); chk("R5 no load after low", 32'(cnt_load), 0);
        wr(0, 8'hAB); chk("R5 load", 32'(cnt_load), 32'b001);
        chk("R5 value", 32'(cnt_value[15:0]), 32'hABCD);
    endtask

    task automatic t_byte_modes();
        wr(3, 8'b01_01_000_0);
        chk("R2 upd ch1", 32'(cfg_update), 32'b010);
        wr(1, 8'h77);
        chk("R4 lo load", 32'(cnt_load), 32'b010);
        chk("R4 lo value", 32'(cnt_value[31:16]), 32'h0077);
        wr(3, 8'b10_10_100_0);
        chk("R2 mode4", 32'(cfg_mode), 4);
        wr(2, 8'h5A);
        chk("R4 hi load", 32'(cnt_load), 32'b100);
        chk("R4 hi value", 32'(cnt_value[47:32]), 32'h5A00);
    endtask

    task automatic t_alias();
        wr(3, 8'b00_11_110_0); chk("R3 mode6", 32'(cfg_mode), 2);
        wr(3, 8'b00_11_111_0); chk("R3 mode7", 32'(cfg_mode), 3);
        wr(3, 8'b00_11_101_0); chk("R3 mode5", 32'(cfg_mode), 5);
    endtask

    task automatic t_reads();
        logic [7:0] d;
        set_live(1, 16'hBEEF); set_live(2, 16'h1357); set_live(0, 16'h2468);
        rd(1, d); chk("R6 lo only", 32'(d), 32'hEF);
        rd(1, d); chk("R6 lo again", 32'(d), 32'hEF);
        rd(2, d); chk("R6 hi only", 32'(d), 32'h13);
        wr(3, 8'b00_11_000_0);
        rd(0, d); chk("R6 word lo", 32'(d), 32'h68);
        rd(0, d); chk("R6 word hi", 32'(d), 32'h24);
        rd(0, d); chk("R6 word lo wrap", 32'(d), 32'h68);
    endtask

    task automatic t_latch();
        logic [7:0] d;
        wr(3, 8'b00_11_000_0);
        set_live(0, 16'h1111);
        wr(0, 8'h44);
        wr(3, 8'b00_00_000_0);
        chk("R7 latch_req", 32'(latch_req), 32'b001);
        chk("R7 no cfg", 32'(cfg_update), 0);
        set_live(0, 16'h2222);
        wr(0, 8'h33);
        chk("R7 wptr kept", 32'(cnt_load), 32'b001);
        chk("R7 value", 32'(cnt_value[15:0]), 32'h3344);
        rd(0, d); chk("R7 snap lo", 32'(d), 32'h11);
        rd(0, d); chk("R7 snap hi", 32'(d), 32'h11);
        rd(0, d); chk("R7 live after", 32'(d), 32'h22);
    endtask

    task automatic t_double_latch();
        logic [7:0] d;
        wr(3, 8'b00_11_000_0);
        set_live(0, 16'hA1B2);
        wr(3, 8'b00_00_000_0); chk("R8 first latch", 32'(latch_req), 32'b001);
        set_live(0, 16'hC3D4);
        wr(3, 8'b00_00_000_0); chk("R8 second ignored", 32'(latch_req), 0);
        rd(0, d); chk("R8 lo", 32'(d), 32'hB2);
        rd(0, d); chk("R8 hi", 32'(d), 32'hA1);
        rd(0, d); chk("R8 live", 32'(d), 32'hD4);
    endtask

    task automatic t_cfg_reset();
        logic [7:0] d;
        wr(3, 8'b00_11_000_0);
        wr(0, 8'h55);
        set_live(0, 16'h9988);
        rd(0, d);
        wr(3, 8'b00_00_000_0);
        wr(3, 8'b00_11_000_0);
        set_live(0, 16'h7766);
        rd(0, d); chk("R9 rptr first, snapshot gone", 32'(d), 32'h66);
        wr(0, 8'h01); chk("R9 wptr low", 32'(cnt_load), 0);
        wr(0, 8'h02); chk("R9 load", 32'(cnt_value[15:0]), 32'h0201);
    endtask

    task automatic t_sel3();
        wr(3, 8'b01_11_000_0);
        wr(1, 8'h10);
        wr(3, 8'b11_01_000_0);
        chk("R10 no upd", 32'(cfg_update), 0);
        wr(3, 8'b11_00_000_0);
        chk("R10 no latch", 32'(latch_req), 0);
        wr(1, 8'h20);
        chk("R10 ch1 load", 32'(cnt_load), 32'b010);
        chk("R10 ch1 value", 32'(cnt_value[31:16]), 32'h2010);
    endtask

    task automatic t_independent();
        wr(3, 8'b00_11_000_0);
        wr(3, 8'b10_11_000_0);
        wr(0, 8'h11);
        wr(2, 8'h22); chk("R12 no load yet", 32'(cnt_load), 0);
        wr(0, 8'h33);
        chk("R1 ch0 only", 32'(cnt_load), 32'b001);
        chk("R12 ch0 value", 32'(cnt_value[15:0]), 32'h3311);
        wr(2, 8'h44);
        chk("R1 ch2 only", 32'(cnt_load), 32'b100);
        chk("R12 ch2 value", 32'(cnt_value[47:32]), 32'h4422);
    endtask

    task automatic t_ctrl_read();
        logic [7:0] d;
        wr(3, 8'b00_11_000_0);
        set_live(0, 16'hABCD);
        rd(0, d); chk("R13 pre lo", 32'(d), 32'hCD);
        rd(3, d); chk("R13 ctrl reads zero", 32'(d), 0);
        rd(0, d); chk("R13 ptr kept", 32'(d), 32'hAB);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_write();
        t_byte_modes();
        t_alias();
        t_reads();
        t_latch();
        t_double_latch();
        t_cfg_reset();
        t_sel3();
        t_independent();
        t_ctrl_read();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule